// File: doc/BRIEF.md
# Shift-Register Addressed Sine Sequencer

This block produces a stepped sine wave as a stream of 4-bit unsigned sample codes. The codes are meant for an external resistor-ladder converter. A 5-bit phase register serves as the table address. On every clock where the step enable is high it moves one place along a fixed shift-register sequence, and the sample stored for the current phase appears on the output.

The phase does not follow a binary count. Each new phase is the old one shifted right by one bit, with a computed feedback bit entering at the top. The feedback is nonlinear, which lets the loop pass through the all-zero phase. One extra term can make the loop skip three phases. The same block therefore serves as a 32-point generator for a high-group tone or as a 29-point generator for a low-group tone, chosen by a parameter. A frequency divider outside the block supplies the step enable.

The run enable parks the phase at the start address and forces the code to mid-scale. A tone therefore begins and ends without a jump in level. A one-clock strobe marks every return to the start of the period.

Top module: `sine_step_seq`

## Requirements
- R1: After reset, phase_addr is 5'b00000, sample_code is 8 and cycle_start is 0.
- R2: While run_en is low, sample_code is 8 in that same cycle. phase_addr becomes 5'b00000 at the next clock edge and stays there whatever step_en does. cycle_start stays 0.
- R3: While run_en is high, every clock edge with step_en high loads a new phase whose bits [3:0] equal the old phase bits [4:1], with the new bit entering at bit 4. An edge with step_en low leaves phase_addr unchanged.
- R4: With NUM_PTS = 32, the phase after 5'b00000 is 5'b10000. The loop visits 32 distinct phases and is back at 5'b00000 after exactly 32 steps.
- R5: With NUM_PTS = 29, the loop visits 29 distinct phases and is back at 5'b00000 after exactly 29 steps. It never visits 5'b00100, 5'b10010 or 5'b01001.
- R6: At the k-th step after the start phase (k taken modulo NUM_PTS), sample_code equals floor(8.25 + 7.7·sin(2πk/NUM_PTS)) as a 4-bit unsigned value. It follows phase_addr within the same cycle.
- R7: cycle_start is high for exactly the one cycle after a step from 5'b00001 back to 5'b00000, and low at all other times, including the cycle in which run_en rises.
- R8: The sample at the start phase is 8, so sample_code does not change when run_en rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | High to generate the tone, low to park at the start phase |
| step_en | input | 1 | One-clock tick from the divider that advances the phase |
| sample_code | output | 4 | Unsigned sample for the ladder converter |
| cycle_start | output | 1 | One-clock strobe on return to the start phase |
| phase_addr | output | 5 | Current table address (phase state) |

## Verification
The phase register and the cycle strobe change one clock edge after a step or a run_en change. The sample code is a combinational function of the phase and of run_en, so it is due in the same cycle as the address it belongs to. The forced mid-scale code is due in the cycle in which run_en falls. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is half a period after the edge that updates them. It makes one extra check a short delay after lowering run_en to catch the same-cycle mid-scale code. The golden samples are indexed by the number of steps since the start phase, not by the address value, so any change to the order of the sequence or to the table shows up as a mismatch.

// File: rtl/sine_seq_pkg.sv
// Package: shared widths, phase constants and the phase-advance function
// used by the sequencer and its table builder.
// Assumes a 5-bit phase; the tap positions are fixed for that width.
package sine_seq_pkg;

    localparam int PH_W   = 5;
    localparam int CODE_W = 4;
    localparam int PH_NUM = 1 << PH_W;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam phase_t START_PH = 5'b00000;  // loop entry, sample 8
    localparam phase_t LAST_PH  = 5'b00001;  // predecessor of START_PH
    localparam phase_t TRIM_PH  = 5'b01000;  // jump point of the 29-step loop
    localparam code_t  MID_CODE = 4'd8;

    // Next phase: shift right, new bit on top. Base taps give a maximal
    // 31-state loop; the zero-detect term splices in 00000; the trim term
    // jumps from TRIM_PH straight to 10100, dropping three states.
    function automatic phase_t next_phase(input phase_t ph, input logic trim);
        logic fb;
        fb = ph[0] ^ ph[2] ^ (ph[PH_W-1:1] == '0);
        if (trim && (ph == TRIM_PH)) begin
            fb = ~fb;
        end
        return {fb, ph[PH_W-1:1]};
    endfunction

endpackage

// File: rtl/sine_phase_reg.sv
// Phase register: holds the table address, parks it at START_PH while the
// tone is off, advances it on each step tick, and flags the wrap from
// LAST_PH back to START_PH. Assumes step_en is a single-cycle tick.
module sine_phase_reg
    import sine_seq_pkg::*;
#(
    parameter int NUM_PTS = 32
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_en,
    input  logic   step_en,
    output phase_t phase_q,
    output logic   wrap_q
);

    localparam logic TRIM = (NUM_PTS == 29);

    phase_t phase_nx;

    // Select the phase to load at the next edge.
    always_comb begin
        if (!run_en) begin
            phase_nx = START_PH;
        end else if (step_en) begin
            phase_nx = next_phase(phase_q, TRIM);
        end else begin
            phase_nx = phase_q;
        end
    end

    // Phase state and one-clock wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= START_PH;
            wrap_q  <= 1'b0;
        end else begin
            phase_q <= phase_nx;
            wrap_q  <= run_en && step_en && (phase_q == LAST_PH);
        end
    end

endmodule

// File: rtl/sine_code_rom.sv
// Sample table: maps each phase to the sample of the position at which
// the loop visits it. The map is built at elaboration by walking the
// phase sequence from START_PH. Phases outside the loop read mid-scale.
// Equal codes on the rising and falling halves are left for synthesis
// to merge into shared decode terms.
module sine_code_rom
    import sine_seq_pkg::*;
#(
    parameter int NUM_PTS = 32
) (
    input  phase_t phase,
    output code_t  code
);

    localparam logic TRIM   = (NUM_PTS == 29);
    localparam int   MAP_W  = PH_NUM * CODE_W;

    // Wave points in visit order: floor(8.25 + 7.7*sin(2*pi*k/N)).
    localparam code_t WAVE_HI [PH_NUM] = '{
        4'd8,  4'd9,  4'd11, 4'd12, 4'd13, 4'd14, 4'd15, 4'd15,
        4'd15, 4'd15, 4'd15, 4'd14, 4'd13, 4'd12, 4'd11, 4'd9,
        4'd8,  4'd6,  4'd5,  4'd3,  4'd2,  4'd1,  4'd1,  4'd0,
        4'd0,  4'd0,  4'd1,  4'd1,  4'd2,  4'd3,  4'd5,  4'd6
    };
    localparam code_t WAVE_LO [PH_NUM] = '{
        4'd8,  4'd9,  4'd11, 4'd12, 4'd14, 4'd15, 4'd15, 4'd15,
        4'd15, 4'd15, 4'd14, 4'd13, 4'd12, 4'd10, 4'd9,  4'd7,
        4'd5,  4'd4,  4'd2,  4'd1,  4'd1,  4'd0,  4'd0,  4'd0,
        4'd1,  4'd2,  4'd3,  4'd5,  4'd6,  4'd8,  4'd8,  4'd8
    };

    // Walk the loop once and place each point at the phase it lands on.
    function automatic logic [MAP_W-1:0] build_map();
        logic [MAP_W-1:0] m;
        phase_t ph;
        for (int s = 0; s < PH_NUM; s++) begin
            m[s*CODE_W +: CODE_W] = MID_CODE;
        end
        ph = START_PH;
        for (int k = 0; k < NUM_PTS; k++) begin
            m[int'(ph)*CODE_W +: CODE_W] = TRIM ? WAVE_LO[k] : WAVE_HI[k];
            ph = next_phase(ph, TRIM);
        end
        return m;
    endfunction

    localparam logic [MAP_W-1:0] CODE_MAP = build_map();

    // Flat decode of the current phase.
    always_comb begin
        code = CODE_MAP[{phase, 2'b00} +: CODE_W];
    end

endmodule

// File: rtl/sine_out_gate.sv
// Output gate: passes the table sample while the tone runs and holds the
// ladder at mid-scale while it is off. Purely combinational.
module sine_out_gate
    import sine_seq_pkg::*;
(
    input  logic  run_en,
    input  code_t code_in,
    output code_t code_out
);

    // Force mid-scale when the tone is off.
    always_comb begin
        code_out = run_en ? code_in : MID_CODE;
    end

endmodule

// File: rtl/sine_step_seq.sv
// Top: stepped sine sequencer. NUM_PTS picks the 32-point loop or the
// trimmed 29-point loop. Assumes step_en comes from an external divider
// and that run_en is synchronous to clk.
module sine_step_seq
    import sine_seq_pkg::*;
#(
    parameter int NUM_PTS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       step_en,
    output logic [3:0] sample_code,
    output logic       cycle_start,
    output logic [4:0] phase_addr
);

    phase_t ph_q;
    logic   wrap_q;
    code_t  raw_code;

    sine_phase_reg #(.NUM_PTS(NUM_PTS)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .step_en (step_en),
        .phase_q (ph_q),
        .wrap_q  (wrap_q)
    );

    sine_code_rom #(.NUM_PTS(NUM_PTS)) u_rom (
        .phase (ph_q),
        .code  (raw_code)
    );

    sine_out_gate u_gate (
        .run_en   (run_en),
        .code_in  (raw_code),
        .code_out (sample_code)
    );

    assign cycle_start = wrap_q;
    assign phase_addr  = ph_q;

endmodule

// File: rtl/sine_step_seq_chk.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module sine_step_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       step_en,
    input logic [3:0] sample_code,
    input logic       cycle_start,
    input logic [4:0] phase_addr
);

    AST_IDLE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> sample_code == 4'd8); // R2

    AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> phase_addr == 5'b00000); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !cycle_start); // R7

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step_en) |=> phase_addr[3:0] == $past(phase_addr[4:1])); // R3

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !step_en) |=> $stable(phase_addr)); // R3

    AST_ZERO_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && step_en && phase_addr == 5'b00000) |=>
            (!run_en || phase_addr == 5'b10000 || phase_addr == 5'b00000)); // R4

    AST_WRAP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (phase_addr == 5'b00000 && $past(phase_addr) == 5'b00001)); // R7

    AST_START_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_addr == 5'b00000) |-> sample_code == 4'd8); // R8

endmodule

bind sine_step_seq sine_step_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .step_en     (step_en),
    .sample_code (sample_code),
    .cycle_start (cycle_start),
    .phase_addr  (phase_addr)
);

// File: tb/test_sine_step_seq.sv
// Directed bench: a 32-point and a 29-point sequencer driven side by side.
module test_sine_step_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic step_en = 1'b0;

    logic [3:0] code_hi, code_lo;
    logic       strb_hi, strb_lo;
    logic [4:0] addr_hi, addr_lo;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sine_step_seq #(.NUM_PTS(32)) i_sine_step_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .step_en(step_en),
        .sample_code(code_hi), .cycle_start(strb_hi), .phase_addr(addr_hi)
    );

    sine_step_seq #(.NUM_PTS(29)) i_sine_step_seq_lo (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .step_en(step_en),
        .sample_code(code_lo), .cycle_start(strb_lo), .phase_addr(addr_lo)
    );

    function automatic int lane_pts(input int ln);
        return (ln == 0) ? 32 : 29;
    endfunction
    function automatic int lane_addr(input int ln);
        return (ln == 0) ? int'(addr_hi) : int'(addr_lo);
    endfunction
    function automatic int lane_code(input int ln);
        return (ln == 0) ? int'(code_hi) : int'(code_lo);
    endfunction
    function automatic int lane_strb(input int ln);
        return (ln == 0) ? int'(strb_hi) : int'(strb_lo);
    endfunction

    // Golden sample of point k of an n-point wave.
    function automatic int gold_code(input int k, input int n);
        real v;
        int  c;
        v = 8.25 + 7.7 * $sin(2.0 * 3.14159265358979 * k / n);
        c = $rtoi($floor(v));
        if (c < 0) c = 0;
        if (c > 15) c = 15;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Reset state on both instances (R1).
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int ln = 0; ln < 2; ln++) begin
            chk(lane_addr(ln) == 0, "R1 addr", lane_addr(ln), 0);
            chk(lane_code(ln) == 8, "R1 code", lane_code(ln), 8);
            chk(lane_strb(ln) == 0, "R1 strobe", lane_strb(ln), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Steps offered while idle are ignored (R2).
    task automatic t_idle();
        run_en  = 1'b0;
        step_en = 1'b1;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            for (int ln = 0; ln < 2; ln++) begin
                chk(lane_addr(ln) == 0, "R2 idle addr", lane_addr(ln), 0);
                chk(lane_code(ln) == 8, "R2 idle code", lane_code(ln), 8);
                chk(lane_strb(ln) == 0, "R2 idle strobe", lane_strb(ln), 0);
            end
        end
        step_en = 1'b0;
    endtask

    // Full walk: order, loop length, samples, strobe (R3-R8).
    task automatic t_walk();
        bit seen [2][32];
        int prev [2];
        int cnt  [2];
        for (int ln = 0; ln < 2; ln++) begin
            for (int s = 0; s < 32; s++) seen[ln][s] = 1'b0;
            cnt[ln] = 0;
        end
        run_en = 1'b1;
        #1;
        for (int ln = 0; ln < 2; ln++) begin
            chk(lane_code(ln) == 8, "R8 code at run start", lane_code(ln), 8);
        end
        @(negedge clk);
        for (int ln = 0; ln < 2; ln++) begin
            chk(lane_addr(ln) == 0, "R8 start addr", lane_addr(ln), 0);
            chk(lane_code(ln) == 8, "R8 start code", lane_code(ln), 8);
            chk(lane_strb(ln) == 0, "R7 no strobe at run start", lane_strb(ln), 0);
            seen[ln][0] = 1'b1;
            cnt[ln] = 1;
            prev[ln] = lane_addr(ln);
        end
        step_en = 1'b1;
        for (int cyc = 1; cyc <= 70; cyc++) begin
            @(negedge clk);
            for (int ln = 0; ln < 2; ln++) begin
                int n, a, k;
                n = lane_pts(ln);
                a = lane_addr(ln);
                k = cyc % n;
                chk((a & 15) == (prev[ln] >> 1), "R3 shift", a, prev[ln] >> 1);
                chk(lane_code(ln) == gold_code(k, n), "R6 sample", lane_code(ln), gold_code(k, n));
                if (cyc == 1 && ln == 0) begin
                    chk(a == 16, "R4 zero escape", a, 16);
                end
                if (k == 0) begin
                    chk(a == 0, (ln == 0) ? "R4 loop length" : "R5 loop length", a, 0);
                    chk(lane_strb(ln) == 1, "R7 strobe on wrap", lane_strb(ln), 1);
                end else begin
                    chk(lane_strb(ln) == 0, "R7 strobe quiet", lane_strb(ln), 0);
                end
                if (cyc < n) begin
                    chk(!seen[ln][a], (ln == 0) ? "R4 repeat" : "R5 repeat", a, -1);
                    seen[ln][a] = 1'b1;
                    cnt[ln]++;
                end
                prev[ln] = a;
            end
        end
        step_en = 1'b0;
        chk(cnt[0] == 32, "R4 distinct count", cnt[0], 32);
        chk(cnt[1] == 29, "R5 distinct count", cnt[1], 29);
        chk(!seen[1][4] && !seen[1][18] && !seen[1][9], "R5 skipped states", 1, 0);
    endtask

    // No step: address and sample stay put (R3).
    task automatic t_pause();
        int a0 [2];
        int c0 [2];
        step_en = 1'b1;
        repeat (5) @(negedge clk);
        step_en = 1'b0;
        @(negedge clk);
        for (int ln = 0; ln < 2; ln++) begin
            a0[ln] = lane_addr(ln);
            c0[ln] = lane_code(ln);
        end
        repeat (4) @(negedge clk);
        for (int ln = 0; ln < 2; ln++) begin
            chk(lane_addr(ln) == a0[ln], "R3 hold addr", lane_addr(ln), a0[ln]);
            chk(lane_code(ln) == c0[ln], "R3 hold code", lane_code(ln), c0[ln]);
            chk(lane_strb(ln) == 0, "R7 quiet in pause", lane_strb(ln), 0);
        end
    endtask

    // Stop mid-period: same-cycle mid-scale, park at start (R2).
    task automatic t_stop();
        run_en  = 1'b0;
        step_en = 1'b1;
        #1;
        for (int ln = 0; ln < 2; ln++) begin
            chk(lane_code(ln) == 8, "R2 code on stop", lane_code(ln), 8);
        end
        @(negedge clk);
        for (int ln = 0; ln < 2; ln++) begin
            chk(lane_addr(ln) == 0, "R2 parked addr", lane_addr(ln), 0);
            chk(lane_strb(ln) == 0, "R2 strobe off", lane_strb(ln), 0);
        end
        step_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_idle();
        t_walk();
        t_pause();
        t_stop();
        t_walk();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYC, 0);
            summary();
            $finish;
        end
    end

endmodule